// File: doc/BRIEF.md
# Periodic Interrupt Generator with Sticky Flag

This block raises the periodic interrupt of a real-time clock. The seconds, minutes and months counters that sit outside the block send it single-cycle strobes when they count up. A small register port picks which of those strobes is the interrupt source and whether the interrupt line behaves as a held level or as a timed pulse.

In level mode, each selected count-up sets a status flag. In the same clock edge it pulls the active-low interrupt low. Both stay asserted until software writes 0 to the flag bit.

In pulse mode, the line goes low on the selected count-up and returns high at the next half-second mark, which gives a 50% duty cycle at the one-second setting. When time trimming is active, every twentieth second the end of that low phase is delayed by a programmable number of clock cycles.

Top module: `pi_irq_gen`

## Requirements
- R1: After a synchronous reset, `flag` is 0, `irq_n` is 1, and both control registers read 0.
- R2: The period field is bits [1:0] of the control register at address 0xE: 0 = no source, 1 = `sec_tick`, 2 = `min_carry`, 3 = `mon_carry`. Strobes from sources that are not selected have no effect on the flag.
- R3: A selected strobe sampled at a clock edge sets `flag` and, in level mode, drives `irq_n` low after that same edge, so both change in the same cycle.
- R4: In level mode, `flag` and `irq_n` stay asserted until a write of a value with bit 2 = 0 to address 0xF. Both are released after the edge of that write.
- R5: A write to address 0xF with bit 2 = 1 leaves `flag` and `irq_n` unchanged.
- R6: If a selected strobe and a clearing write arrive at the same edge, `flag` stays set.
- R7: Pulse mode is bit 3 of address 0xE. In pulse mode, `irq_n` goes low after the edge that samples a selected strobe. It goes high after the edge that samples the next `half_tick`.
- R8: With `trim_en` high, on the second that begins with every 20th `sec_tick` after reset, the pulse-mode low phase ends `trim_dly` cycles after the `half_tick` edge instead of at it. With `trim_en` low, that second is not extended.
- R9: In pulse mode, the selected strobe still sets `flag`, and `irq_n` follows the pulse and not the flag.
- R10: `rd_data` is registered one cycle after `rd_addr`. Address 0xE returns {4'b0, pulse, 1'b0, period}, address 0xF returns the flag in bit 2, and any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe at each seconds count-up |
| min_carry | input | 1 | One-cycle strobe at each minutes count-up |
| mon_carry | input | 1 | One-cycle strobe at each months count-up |
| half_tick | input | 1 | One-cycle strobe at the middle of each second |
| trim_en | input | 1 | Time trimming active |
| trim_dly | input | 4 | Extra low cycles on trimmed seconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Registered read data |
| flag | output | 1 | Periodic interrupt status flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench selects each period in turn and fires all three strobes. This shows that only the chosen source sets the flag, and that the "no source" setting ignores all of them.

In level mode, the bench probes the flag with a write of 0, a write of 1, and a clear that lands on the same edge as a new count-up. These three cases separate the clear from a no-op and from the priority of the count-up.

In pulse mode, the bench runs forty short seconds, first with trimming on and then with it off. This separates the plain half-second release from the release delayed every twentieth second. It also shows that the flag keeps its value while the line follows the pulse.

// File: rtl/pi_pkg.sv
package pi_pkg;
  typedef enum logic [1:0] {
    PER_OFF = 2'd0,
    PER_SEC = 2'd1,
    PER_MIN = 2'd2,
    PER_MON = 2'd3
  } per_e;

  typedef struct packed {
    logic pulse;
    per_e per;
  } ctrl_t;
endpackage

// File: rtl/pi_event_sel.sv
module pi_event_sel
  import pi_pkg::*;
(
  input  per_e per,
  input  logic sec_tick,
  input  logic min_carry,
  input  logic mon_carry,
  output logic ev
);
  always_comb begin
    unique case (per)
      PER_SEC: ev = sec_tick;
      PER_MIN: ev = min_carry;
      PER_MON: ev = mon_carry;
      default: ev = 1'b0;
    endcase
  end
endmodule

// File: rtl/pi_pulse_timer.sv
module pi_pulse_timer #(
  parameter int TRIM_W   = 4,
  parameter int TRIM_SEC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              half_tick,
  input  logic              ev,
  input  logic              trim_en,
  input  logic [TRIM_W-1:0] trim_dly,
  output logic              pulse_nxt
);
  localparam int CNT_W = $clog2(TRIM_SEC);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRIM_SEC - 1);

  logic [CNT_W-1:0]  sec_cnt;
  logic              slot;
  logic [TRIM_W-1:0] ext, ext_nxt;
  logic              pulse_low;

  // Low-phase control: extension countdown first, then half-second release.
  always_comb begin
    ext_nxt   = ext;
    pulse_nxt = pulse_low;
    if (ext != '0) begin
      ext_nxt = ext - 1'b1;
      if (ext == TRIM_W'(1)) pulse_nxt = 1'b0;
    end else if (half_tick && pulse_low) begin
      if (slot && trim_en && trim_dly != '0) ext_nxt = trim_dly;
      else pulse_nxt = 1'b0;
    end
    if (ev) pulse_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_cnt   <= '0;
      slot      <= 1'b0;
      ext       <= '0;
      pulse_low <= 1'b0;
    end else begin
      if (sec_tick) sec_cnt <= (sec_cnt == CNT_LAST) ? '0 : sec_cnt + 1'b1;
      if (sec_tick && sec_cnt == CNT_LAST) slot <= 1'b1;
      else if (half_tick) slot <= 1'b0;
      ext       <= ext_nxt;
      pulse_low <= pulse_nxt;
    end
  end

  // R8: while the extension is still running the pulse stays low
  a_r8_ext_holds: assert property (@(posedge clk) disable iff (rst)
    (ext > TRIM_W'(1)) |=> pulse_low);

  // R7: a selected event always makes the pulse low
  a_r7_ev_starts: assert property (@(posedge clk) disable iff (rst)
    ev |=> pulse_low);
endmodule

// File: rtl/pi_regs.sv
module pi_regs
  import pi_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 2,
  parameter logic [ADDR_W-1:0] CTRL1_ADDR = 4'hE,
  parameter logic [ADDR_W-1:0] CTRL2_ADDR = 4'hF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              ev,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic              flag_nxt,
  output logic [DATA_W-1:0] rd_data
);
  logic clr_wr, ctrl_wr;
  logic [DATA_W-1:0] rd_nxt;
  logic unused_wdata;

  assign ctrl_wr = wr_en && (wr_addr == CTRL1_ADDR);
  assign clr_wr  = wr_en && (wr_addr == CTRL2_ADDR) && !wr_data[FLAG_BIT];
  assign unused_wdata = ^{wr_data[DATA_W-1:4], wr_data[2]};

  // Count-up has priority over the software clear.
  always_comb begin
    if (ev)          flag_nxt = 1'b1;
    else if (clr_wr) flag_nxt = 1'b0;
    else             flag_nxt = flag;
  end

  always_comb begin
    rd_nxt = '0;
    if (rd_addr == CTRL1_ADDR) begin
      rd_nxt[3]   = ctrl.pulse;
      rd_nxt[1:0] = ctrl.per;
    end else if (rd_addr == CTRL2_ADDR) begin
      rd_nxt[FLAG_BIT] = flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= '0;
      flag    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl.pulse <= wr_data[3];
        ctrl.per   <= per_e'(wr_data[1:0]);
      end
      flag    <= flag_nxt;
      rd_data <= rd_nxt;
    end
  end

  // R3 / R6: a selected count-up always leaves the flag set
  a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
    ev |=> flag);
  // R5: without a clearing write the flag is held
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (flag && !(wr_en && wr_addr == CTRL2_ADDR && !wr_data[FLAG_BIT])) |=> flag);
  // R4: the flag never rises without an event
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (rst)
    (!flag && !ev) |=> !flag);
endmodule

// File: rtl/pi_irq_gen.sv
module pi_irq_gen
  import pi_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int TRIM_W   = 4,
  parameter int TRIM_SEC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              min_carry,
  input  logic              mon_carry,
  input  logic              half_tick,
  input  logic              trim_en,
  input  logic [TRIM_W-1:0] trim_dly,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              flag,
  output logic              irq_n
);
  ctrl_t ctrl;
  logic  ev, flag_nxt, pulse_nxt;

  pi_event_sel u_sel (
    .per(ctrl.per), .sec_tick(sec_tick), .min_carry(min_carry),
    .mon_carry(mon_carry), .ev(ev)
  );

  pi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .ev(ev), .ctrl(ctrl),
    .flag(flag), .flag_nxt(flag_nxt), .rd_data(rd_data)
  );

  pi_pulse_timer #(.TRIM_W(TRIM_W), .TRIM_SEC(TRIM_SEC)) u_pulse (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .half_tick(half_tick),
    .ev(ev), .trim_en(trim_en), .trim_dly(trim_dly), .pulse_nxt(pulse_nxt)
  );

  // Registered output, updated on the same edge as the flag.
  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ctrl.pulse ? !pulse_nxt : !flag_nxt;
  end

  // R1: reset leaves the flag clear and the line released
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!flag && irq_n));
endmodule

// File: tb/sim_pi_irq_gen.sv
module sim_pi_irq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 0, min_carry = 0, mon_carry = 0, half_tick = 0;
  logic       trim_en = 0;
  logic [3:0] trim_dly = 0;
  logic       wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       flag, irq_n;

  int checks = 0, fails = 0, sec_count = 0;
  string cur_req = "R1";

  // Behavioural reference state
  int m_flag = 0, m_irq = 1, m_pulse = 0, m_ext = 0, m_cnt = 0, m_slot = 0;
  int m_mode = 0, m_per = 0, m_rd = 0;

  always #5 clk = ~clk;

  pi_irq_gen u0 (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .min_carry(min_carry),
    .mon_carry(mon_carry), .half_tick(half_tick), .trim_en(trim_en),
    .trim_dly(trim_dly), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .flag(flag), .irq_n(irq_n)
  );

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    int ev, n_flag, n_pulse, n_ext, n_cnt, n_slot, n_rd;
    if (rst) begin
      n_flag = 0; n_pulse = 0; n_ext = 0; n_cnt = 0; n_slot = 0; n_rd = 0;
      m_irq = 1; m_mode = 0; m_per = 0;
    end else begin
      ev = (m_per == 1 && sec_tick) || (m_per == 2 && min_carry) ||
           (m_per == 3 && mon_carry);
      if (ev) n_flag = 1;
      else if (wr_en && wr_addr == 4'hF && !wr_data[2]) n_flag = 0;
      else n_flag = m_flag;
      n_cnt = m_cnt; n_slot = m_slot;
      if (sec_tick) begin
        sec_count++;
        if (m_cnt == 19) begin n_cnt = 0; n_slot = 1; end
        else n_cnt = m_cnt + 1;
      end
      if (!(sec_tick && m_cnt == 19) && half_tick) n_slot = 0;
      n_pulse = m_pulse; n_ext = m_ext;
      if (m_ext > 0) begin
        n_ext = m_ext - 1;
        if (m_ext == 1) n_pulse = 0;
      end else if (half_tick && m_pulse == 1) begin
        if (m_slot == 1 && trim_en && trim_dly != 0) n_ext = trim_dly;
        else n_pulse = 0;
      end
      if (ev) n_pulse = 1;
      m_irq = m_mode ? !n_pulse : !n_flag;
      n_rd = (rd_addr == 4'hE) ? (m_mode * 8 + m_per) :
             (rd_addr == 4'hF) ? (m_flag * 4) : 0;
      if (wr_en && wr_addr == 4'hE) begin
        m_mode = wr_data[3]; m_per = wr_data[1:0];
      end
    end
    m_flag = n_flag; m_pulse = n_pulse; m_ext = n_ext;
    m_cnt = n_cnt; m_slot = n_slot; m_rd = n_rd;
    @(posedge clk);
    @(negedge clk);
    check({cur_req, " irq_n"}, irq_n, m_irq);
    check({cur_req, " flag"}, flag, m_flag);
    check({cur_req, " rd_data"}, rd_data, m_rd);
    sec_tick = 0; min_carry = 0; mon_carry = 0; half_tick = 0; wr_en = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // One short second: count-up, half-second mark at cycle 4, 8 cycles total
  task automatic second(int xmin, int xmon);
    sec_tick = 1; min_carry = 1'(xmin); mon_carry = 1'(xmon); tick();
    idle(3);
    half_tick = 1; tick();
    idle(3);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    cur_req = "R1";
    idle(2);
    rd_addr = 4'hE; idle(1);
    rst = 0;
    idle(1);
    check("R1 flag after reset", flag, 0);
    check("R1 irq_n after reset", irq_n, 1);
    check("R1 ctrl1 after reset", rd_data, 0);

    cur_req = "R10";
    wr(4'hE, 8'h01); idle(1);
    check("R10 ctrl1 readback", rd_data, 8'h01);

    cur_req = "R3";
    sec_tick = 1; tick();
    check("R3 flag set", flag, 1);
    check("R3 irq_n low", irq_n, 0);
    cur_req = "R4";
    idle(3);
    check("R4 still held", irq_n, 0);
    cur_req = "R5";
    wr(4'hF, 8'hFF);
    check("R5 write 1 no effect", flag, 1);
    check("R5 irq_n unchanged", irq_n, 0);
    cur_req = "R10";
    rd_addr = 4'hF; idle(1);
    check("R10 flag readback", rd_data, 8'h04);
    cur_req = "R4";
    wr(4'hF, 8'h00);
    check("R4 cleared flag", flag, 0);
    check("R4 cleared irq_n", irq_n, 1);

    cur_req = "R6";
    sec_tick = 1; wr_en = 1; wr_addr = 4'hF; wr_data = 8'h00; tick();
    check("R6 event beats clear", flag, 1);
    wr(4'hF, 8'h00);

    cur_req = "R2";
    wr(4'hE, 8'h02);
    sec_tick = 1; mon_carry = 1; tick();
    check("R2 minute ignores sec/month", flag, 0);
    min_carry = 1; tick();
    check("R2 minute carry sets", flag, 1);
    wr(4'hF, 8'h00);
    wr(4'hE, 8'h03);
    sec_tick = 1; min_carry = 1; tick();
    check("R2 month ignores sec/min", flag, 0);
    mon_carry = 1; tick();
    check("R2 month carry sets", flag, 1);
    wr(4'hF, 8'h00);
    wr(4'hE, 8'h00);
    sec_tick = 1; min_carry = 1; mon_carry = 1; tick();
    check("R2 off ignores all", flag, 0);
    check("R2 off irq_n", irq_n, 1);

    cur_req = "R7";
    wr(4'hE, 8'h09);
    sec_tick = 1; tick();
    check("R7 pulse low", irq_n, 0);
    idle(3);
    check("R7 still low before half", irq_n, 0);
    half_tick = 1; tick();
    check("R7 released at half", irq_n, 1);
    check("R9 flag stays set in pulse mode", flag, 1);
    idle(3);

    cur_req = "R8";
    trim_en = 1; trim_dly = 4'd3;
    for (int s = 0; s < 40; s++) begin
      if (s == 25) trim_en = 0;
      sec_tick = 1; tick();
      idle(3);
      half_tick = 1; tick();
      if (sec_count % 20 == 0 && trim_en) begin
        check("R8 extended low", irq_n, 0);
        idle(2);
        check("R8 still low", irq_n, 0);
        idle(1);
        check("R8 released after trim", irq_n, 1);
        idle(0);
      end else begin
        check("R8 normal release", irq_n, 1);
        idle(3);
        continue;
      end
    end

    cur_req = "R9";
    wr(4'hF, 8'h00);
    check("R9 clear in pulse mode", flag, 0);
    second(0, 0);
    check("R9 flag set by pulse-mode event", flag, 1);
    check("R9 irq_n follows pulse", irq_n, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule